// File: doc/BRIEF.md
# Programmable Pulse-Swallow Feedback Divider

This block divides a fast oscillator-rate clock by a programmable integer N and gives one single-cycle pulse per N input cycles, for use as the feedback edge of a PLL. The division works the classic way. A small dual-modulus prescaler divides by P or by P+1. In each output period a main counter counts M prescaler periods, and a swallow counter holds the prescaler in the P+1 mode for the first S of them. The result is N = M*P + S, with M = N div P and S = N mod P.

In silicon the higher modulus comes from removing one input clock pulse by gating. Here the gated pulse is modelled as a synchronous hold enable on the prescaler state. A guard remembers whether the previous input cycle was removed and blocks the removal of two cycles in a row, so the prescaler always leaves its terminal state. The programmed ratio is read only at the end of an output period (and while reset is held). A ratio below the smallest one the structure can produce is raised to that minimum. There is no data stream through the block: every pin is a plain control or status signal.

Top module: `swallow_divider`

## Requirements
- R1: After the synchronous active-high reset is released, the first `div_pulse` is high during the cycle that follows the N-th rising clock edge counted from the first edge with reset low, where N is the ratio present on `div_n` at the last reset edge.
- R2: With a constant ratio, `div_pulse` is high for exactly one clock cycle out of every N, and the pulses are exactly N cycles apart.
- R3: The ratio is split as M = N div P and S = N mod P, with P = 4 by default. Within each output period the first S prescaler periods last P+1 input cycles and the remaining M-S periods last P cycles, so every value of S from 0 to P-1 gives a total of N cycles.
- R4: The prescaler never removes two input pulses in consecutive cycles. After a removed cycle it always completes its period in the next cycle.
- R5: A ratio below P*(P-1) (12 by default) is treated as exactly P*(P-1), so pulses are then 12 cycles apart.
- R6: `div_n` is sampled only on the edge that ends an output period (and on reset edges). A change in the middle of a period does not alter that period, and it sets the length of the following one.
- R7: While reset is asserted, `div_pulse` is low.
- R8: The largest ratio, 2^NW - 1 (1023 by default), gives pulses exactly that many cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate input clock |
| rst | input | 1 | Synchronous active-high reset; loads the ratio on `div_n` |
| div_n | input | NW (10) | Programmed division ratio N, unsigned |
| div_pulse | output | 1 | One-cycle pulse at the end of each output period |

## Verification
The assertions take for granted that every ratio loaded into the counters has already been clamped. That means the swallow count never exceeds the main count, and output pulses can never be closer than the minimum ratio. These conditions hold only because of the clamp in the ratio splitter, so the stimulus deliberately drives ratios below the minimum, including zero, along with the boundary values 12 and 1023 and every residue modulo P. Random ratio changes are applied at arbitrary cycles, often in the middle of a period. The bench model therefore tracks which value was present on the period-ending edge, and the random ratios are capped at a few hundred so that many periods fit in the run.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  // Smallest ratio for which the swallow count never exceeds the main count.
  function automatic int unsigned swdiv_min_ratio(input int unsigned pre);
    return pre * (pre - 1);
  endfunction

endpackage

// File: rtl/swdiv_ratio.sv
module swdiv_ratio
  import swdiv_pkg::*;
#(
  parameter int unsigned PRE = 4,
  parameter int unsigned NW  = 10,
  localparam int unsigned PW = (PRE > 2) ? $clog2(PRE) : 1
) (
  input  logic [NW-1:0] ratio_in,
  output logic [NW-1:0] main_ld,
  output logic [PW-1:0] swal_ld
);

  localparam int unsigned NMIN = swdiv_min_ratio(PRE);

  logic [NW-1:0] ratio_ok;

  // Ratios below the structural minimum are raised to it.
  always_comb begin
    if (ratio_in < NW'(NMIN)) ratio_ok = NW'(NMIN);
    else                      ratio_ok = ratio_in;
    main_ld = ratio_ok / NW'(PRE);
    swal_ld = PW'(ratio_ok % NW'(PRE));
  end

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int unsigned PRE = 4,
  localparam int unsigned PW = (PRE > 2) ? $clog2(PRE) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_hi,
  output logic tick
);

  logic [PW-1:0] phase_q;
  logic          gated_q;
  logic          gate;
  logic          at_term;

  always_comb begin
    at_term = (phase_q == PW'(PRE - 1));
    // Remove one input pulse in the terminal state, never twice in a row.
    gate    = mode_hi && at_term && !gated_q;
    tick    = at_term && !gate;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      gated_q <= 1'b0;
    end else begin
      gated_q <= gate;
      if (!gate) begin
        if (at_term) phase_q <= '0;
        else         phase_q <= phase_q + PW'(1);
      end
    end
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    gate |=> !gate); // R4

  AST_TICK_AFTER_GATE: assert property (@(posedge clk) disable iff (rst)
    gate |=> tick); // R3

endmodule

// File: rtl/swdiv_counter.sv
module swdiv_counter
  import swdiv_pkg::*;
#(
  parameter int unsigned PRE = 4,
  parameter int unsigned NW  = 10,
  localparam int unsigned PW = (PRE > 2) ? $clog2(PRE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [NW-1:0] main_ld,
  input  logic [PW-1:0] swal_ld,
  output logic          mode_hi,
  output logic          pulse
);

  localparam int unsigned NMIN = swdiv_min_ratio(PRE);

  logic [NW-1:0] main_q;
  logic [PW-1:0] swal_q;
  logic          last;

  always_comb begin
    last    = (main_q == NW'(1));
    mode_hi = (swal_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= main_ld;
      swal_q <= swal_ld;
      pulse  <= 1'b0;
    end else begin
      pulse <= tick && last;
      if (tick) begin
        if (last) begin
          main_q <= main_ld;
          swal_q <= swal_ld;
        end else begin
          main_q <= main_q - NW'(1);
          if (swal_q != '0) swal_q <= swal_q - PW'(1);
        end
      end
    end
  end

  // Cycles since the last pulse, saturating; used by the spacing check.
  logic [NW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)                    gap_q <= '0;
    else if (pulse)             gap_q <= NW'(1);
    else if (gap_q != '1)       gap_q <= gap_q + NW'(1);
  end

  AST_SWALLOW_WITHIN_MAIN: assert property (@(posedge clk) disable iff (rst)
    NW'(swal_q) <= main_q); // R3

  AST_LOAD_FEASIBLE: assert property (@(posedge clk) disable iff (rst)
    (tick && last) |-> (NW'(swal_ld) <= main_ld && main_ld != '0)); // R5

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse); // R2

  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst)
    pulse |-> gap_q >= NW'(NMIN)); // R5

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int unsigned PRE = 4,
  parameter int unsigned NW  = 10,
  localparam int unsigned PW = (PRE > 2) ? $clog2(PRE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] div_n,
  output logic          div_pulse
);

  logic [NW-1:0] main_ld;
  logic [PW-1:0] swal_ld;
  logic          mode_hi;
  logic          tick;

  swdiv_ratio #(.PRE(PRE), .NW(NW)) u_ratio (
    .ratio_in (div_n),
    .main_ld  (main_ld),
    .swal_ld  (swal_ld)
  );

  swdiv_prescaler #(.PRE(PRE)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .mode_hi (mode_hi),
    .tick    (tick)
  );

  swdiv_counter #(.PRE(PRE), .NW(NW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .main_ld (main_ld),
    .swal_ld (swal_ld),
    .mode_hi (mode_hi),
    .pulse   (div_pulse)
  );

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    rst |=> !div_pulse); // R7

endmodule

// File: tb/test_swallow_divider.sv
module test_swallow_divider;

  localparam int CLK_PERIOD = 10;
  localparam int NMIN       = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] div_n = 10'd20;
  logic       div_pulse;

  int checks = 0;
  int errors = 0;
  int rem    = 0;

  swallow_divider i_swallow_divider (
    .clk       (clk),
    .rst       (rst),
    .div_n     (div_n),
    .div_pulse (div_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clampn(input int n);
    return (n < NMIN) ? NMIN : n;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: div_pulse actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int n);
    rst   = 1'b1;
    div_n = 10'(n);
    repeat (3) @(negedge clk);
    check(div_pulse, 1'b0, "R7");
    rst = 1'b0;
    rem = clampn(n);
  endtask

  // One edge: advance the model, compare, reload on period end.
  task automatic step(input string tag);
    logic exp;
    @(negedge clk);
    rem--;
    exp = (rem == 0);
    check(div_pulse, exp, tag);
    if (exp) rem = clampn(int'(div_n));
  endtask

  task automatic run(input int n, input int cycles, input string tag);
    do_reset(n);
    for (int i = 0; i < clampn(n); i++) step("R1");
    for (int i = 0; i < cycles; i++) step(tag);
  endtask

  initial begin
    process::self().srandom(32'd7);
    run(12, 60, "R2");        // minimum ratio, S = 0
    run(13, 60, "R3");        // S = 1
    run(14, 60, "R3");        // S = 2
    run(15, 60, "R4");        // S = P-1: most removals per period
    run(5, 48, "R5");         // below minimum
    run(0, 48, "R5");         // zero
    run(1023, 2100, "R8");    // largest ratio
    // Mid-period change: only the next period takes it.
    do_reset(20);
    for (int i = 0; i < 7; i++) step("R1");
    div_n = 10'd33;
    for (int i = 0; i < 13; i++) step("R6");
    for (int i = 0; i < 99; i++) step("R6");
    div_n = 10'd2;
    for (int i = 0; i < 40; i++) step("R6");
    // Random ratios changed at random cycles.
    for (int seg = 0; seg < 6; seg++) begin
      do_reset(int'($urandom_range(0, 200)));
      for (int i = 0; i < 2500; i++) begin
        step("R2");
        if ($urandom_range(0, 39) == 0) div_n = 10'($urandom_range(0, 200));
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule